// File: doc/BRIEF.md
# Voltage Regulator Startup Sequencer

This block steps a multiphase regulator controller through its power-up sequence. Both the enable input and the supply-ok flag must be high before anything starts. The block then waits a fixed delay and opens a short phase-detection window with every PWM output held off. Next it turns on soft-start so that the reference rises to a fixed boot level, and it holds that level while the processor's voltage code settles. It then captures the voltage code once and switches the reference to it. After a masking interval and a second delay, it raises power-good.

The analog reference, the DAC and the ramp generator sit outside the block. An external model reports the end of each ramp with the `rampDone` input. The delay, boot-hold and power-good delay all run on one shared timer of `TIMER_TICKS` clocks. The phase window and the power-good mask have their own tick counts. When enable or supply-ok drops at any point, the block returns to idle.

Top module: `vr_startup_seq`

## Requirements
- R1: The sequence leaves idle only when `enable` and `uvloOk` are both high at a clock edge. If either is low at an edge in any other state, the next state is idle (`stateCode` 0).
- R2: The first stage (`stateCode` 1) lasts exactly `TIMER_TICKS` clocks. `rampDone` has no effect during this stage.
- R3: The phase-detect stage (`stateCode` 2) lasts exactly `PHASE_CLKS` clocks. During it, `phaseWindow` and `pwmBlank` are both high and `softStartEn` is low.
- R4: The boot ramp (`stateCode` 3) keeps `softStartEn` high and `refSelCode` low (0 selects the boot level) until `rampDone` is seen high at an edge. The hold stage (`stateCode` 4) follows.
- R5: The hold stage lasts `TIMER_TICKS` clocks. `vidCode` changes during the hold leave `latchedCode` unchanged. `codeLatch` is high only in the last hold clock, and `latchedCode` takes the value `vidCode` had in that clock.
- R6: The code ramp (`stateCode` 5) drives `refSelCode` high (1 selects the latched code) until `rampDone`. `latchedCode` does not change after the single capture.
- R7: After the code ramp, the mask stage (`stateCode` 6) lasts `MASK_TICKS` clocks. The power-good delay (`stateCode` 7) then lasts `TIMER_TICKS` clocks. The run state (`stateCode` 8) follows.
- R8: `powerGood` is high only in the run state. It falls in the same cycle that `enable` or `uvloOk` goes low, without waiting for a clock edge.
- R9: `stateOneHot` has exactly one bit set, and that bit is at the index equal to `stateCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Regulator enable |
| uvloOk | input | 1 | Supply above the undervoltage threshold |
| rampDone | input | 1 | External ramp has reached its target |
| vidCode | input | CODE_W | Voltage code from the processor |
| stateCode | output | 4 | Current stage, 0 (idle) to 8 (run) |
| stateOneHot | output | 9 | One-hot copy of the stage |
| refSelCode | output | 1 | Reference select: 0 = boot level, 1 = latched code |
| pwmBlank | output | 1 | All PWM outputs forced off |
| phaseWindow | output | 1 | Phase-detection window |
| softStartEn | output | 1 | Soft-start ramp enabled |
| codeLatch | output | 1 | Capture strobe for the voltage code |
| latchedCode | output | CODE_W | Captured voltage code |
| powerGood | output | 1 | Regulator output is good |

## Verification
A corrupted stage register shows up on `stateCode` and on the strobes within one clock. A timer that ends early or late moves the stage change off its expected clock, so the bench checks each stage boundary on the exact clock it should occur. A capture at the wrong time shows on `latchedCode` in the next cycle, as soon as the bench changes `vidCode` during the hold or the code ramp. A missing abort path leaves `powerGood` or a nonzero `stateCode` up one clock after `enable` or `uvloOk` falls.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;
  localparam int NUM_STATES = 9;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_DELAY      = 4'd1,
    ST_PHASE_DET  = 4'd2,
    ST_RAMP_BOOT  = 4'd3,
    ST_BOOT_HOLD  = 4'd4,
    ST_RAMP_CODE  = 4'd5,
    ST_PG_MASK    = 4'd6,
    ST_PG_DELAY   = 4'd7,
    ST_RUN        = 4'd8
  } seqState_t;

  typedef struct packed {
    logic clrTimer;   // restart the shared tick counter
    logic latchCode;  // capture the voltage code this cycle
  } seqStrobe_t;
endpackage

// File: rtl/vrseq_dpath.sv
module vrseq_dpath
  import vrseq_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int TIMER_TICKS = 40,
  parameter int PHASE_CLKS  = 6,
  parameter int MASK_TICKS  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CODE_W-1:0] vidCode,
  output logic [CODE_W-1:0] latchedCode,
  output logic              timerDone,
  output logic              phaseDone,
  output logic              maskDone
);
  localparam int MAX_A  = (TIMER_TICKS > PHASE_CLKS) ? TIMER_TICKS : PHASE_CLKS;
  localparam int MAX_T  = (MAX_A > MASK_TICKS) ? MAX_A : MASK_TICKS;
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MAX_T);
  localparam logic [CNT_W-1:0] TMR_LAST = CNT_W'(TIMER_TICKS - 1);
  localparam logic [CNT_W-1:0] PHS_LAST = CNT_W'(PHASE_CLKS - 1);
  localparam logic [CNT_W-1:0] MSK_LAST = CNT_W'(MASK_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;

  // Shared tick counter: cleared on every stage change, saturating otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tickCnt <= '0;
    else if (strobe.clrTimer)   tickCnt <= '0;
    else if (tickCnt != CNT_SAT) tickCnt <= tickCnt + 1'b1;
  end

  assign timerDone = (tickCnt == TMR_LAST);
  assign phaseDone = (tickCnt == PHS_LAST);
  assign maskDone  = (tickCnt == MSK_LAST);

  // Voltage code capture register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 latchedCode <= '0;
    else if (strobe.latchCode) latchedCode <= vidCode;
  end

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchCode |=> $stable(latchedCode)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrTimer && tickCnt != CNT_SAT) |=> (tickCnt == $past(tickCnt) + 1'b1)); // R2
endmodule

// File: rtl/vrseq_ctrl.sv
module vrseq_ctrl
  import vrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       uvloOk,
  input  logic       rampDone,
  input  logic       timerDone,
  input  logic       phaseDone,
  input  logic       maskDone,
  output seqStrobe_t strobe,
  output seqState_t  state,
  output logic       refSelCode,
  output logic       pwmBlank,
  output logic       phaseWindow,
  output logic       softStartEn,
  output logic       powerGood
);
  seqState_t nextState;
  logic      supplyOk;

  assign supplyOk = enable & uvloOk;

  always_comb begin
    nextState = state;
    if (!supplyOk) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:      nextState = ST_DELAY;
        ST_DELAY:     if (timerDone) nextState = ST_PHASE_DET;
        ST_PHASE_DET: if (phaseDone) nextState = ST_RAMP_BOOT;
        ST_RAMP_BOOT: if (rampDone)  nextState = ST_BOOT_HOLD;
        ST_BOOT_HOLD: if (timerDone) nextState = ST_RAMP_CODE;
        ST_RAMP_CODE: if (rampDone)  nextState = ST_PG_MASK;
        ST_PG_MASK:   if (maskDone)  nextState = ST_PG_DELAY;
        ST_PG_DELAY:  if (timerDone) nextState = ST_RUN;
        ST_RUN:       nextState = ST_RUN;
        default:      nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe           = '0;
    strobe.clrTimer  = (nextState != state);
    strobe.latchCode = supplyOk && (state == ST_BOOT_HOLD) && timerDone;
  end

  assign pwmBlank    = (state == ST_IDLE) || (state == ST_DELAY) || (state == ST_PHASE_DET);
  assign phaseWindow = (state == ST_PHASE_DET);
  assign softStartEn = (state >= ST_RAMP_BOOT) && (state <= ST_RUN);
  assign refSelCode  = (state >= ST_RAMP_CODE) && (state <= ST_RUN);
  assign powerGood   = (state == ST_RUN) && supplyOk;

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (state == ST_IDLE)); // R1

  AST_BLANK_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    phaseWindow |-> (pwmBlank && !softStartEn)); // R3

  AST_PG_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGood) |-> ($past(state) == ST_PG_DELAY)); // R8

  AST_LATCH_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchCode |=> (state == ST_RAMP_CODE)); // R5

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !supplyOk) |=> (state == ST_IDLE)); // R1
endmodule

// File: rtl/vr_startup_seq.sv
module vr_startup_seq
  import vrseq_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int TIMER_TICKS = 40,
  parameter int PHASE_CLKS  = 6,
  parameter int MASK_TICKS  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              uvloOk,
  input  logic              rampDone,
  input  logic [CODE_W-1:0] vidCode,
  output logic [3:0]        stateCode,
  output logic [8:0]        stateOneHot,
  output logic              refSelCode,
  output logic              pwmBlank,
  output logic              phaseWindow,
  output logic              softStartEn,
  output logic              codeLatch,
  output logic [CODE_W-1:0] latchedCode,
  output logic              powerGood
);
  seqStrobe_t strobe;
  seqState_t  state;
  logic       timerDone;
  logic       phaseDone;
  logic       maskDone;

  vrseq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .uvloOk      (uvloOk),
    .rampDone    (rampDone),
    .timerDone   (timerDone),
    .phaseDone   (phaseDone),
    .maskDone    (maskDone),
    .strobe      (strobe),
    .state       (state),
    .refSelCode  (refSelCode),
    .pwmBlank    (pwmBlank),
    .phaseWindow (phaseWindow),
    .softStartEn (softStartEn),
    .powerGood   (powerGood)
  );

  vrseq_dpath #(
    .CODE_W      (CODE_W),
    .TIMER_TICKS (TIMER_TICKS),
    .PHASE_CLKS  (PHASE_CLKS),
    .MASK_TICKS  (MASK_TICKS)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .vidCode     (vidCode),
    .latchedCode (latchedCode),
    .timerDone   (timerDone),
    .phaseDone   (phaseDone),
    .maskDone    (maskDone)
  );

  assign stateCode = state;
  assign codeLatch = strobe.latchCode;

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_onehot
    assign stateOneHot[i] = (stateCode == 4'(i));
  end

  AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(stateOneHot) == 1) && stateOneHot[stateCode]); // R9
endmodule

// File: tb/vr_startup_seq_tb.sv
module vr_startup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 8;
  localparam int TT = 20;
  localparam int PC = 6;
  localparam int MT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, uvloOk = 1'b0, rampDone = 1'b0;
  logic [CODE_W-1:0] vidCode = '0;
  logic [3:0] stateCode;
  logic [8:0] stateOneHot;
  logic refSelCode, pwmBlank, phaseWindow, softStartEn, codeLatch, powerGood;
  logic [CODE_W-1:0] latchedCode;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vr_startup_seq #(.CODE_W(CODE_W), .TIMER_TICKS(TT), .PHASE_CLKS(PC), .MASK_TICKS(MT)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .uvloOk(uvloOk), .rampDone(rampDone),
    .vidCode(vidCode), .stateCode(stateCode), .stateOneHot(stateOneHot),
    .refSelCode(refSelCode), .pwmBlank(pwmBlank), .phaseWindow(phaseWindow),
    .softStartEn(softStartEn), .codeLatch(codeLatch), .latchedCode(latchedCode),
    .powerGood(powerGood)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chkState(input int exp, input string tag);
    chk(stateCode == 4'(exp), tag, stateCode, exp);
    chk(stateOneHot == 9'(1 << exp), {tag, " R9 onehot"}, stateOneHot, 1 << exp);
  endtask

  // Drive from idle to the first clock of the boot ramp.
  task automatic startToRamp();
    enable = 1; uvloOk = 1;
    tick();
    chkState(1, "R1 start");
    rampDone = 1;              // R2: ignored in the first stage
    tick(TT - 1);
    rampDone = 0;
    chkState(1, "R2 delay end");
    tick();
    for (int i = 0; i < PC; i++) begin
      chkState(2, "R3 phase");
      chk(phaseWindow && pwmBlank && !softStartEn, "R3 strobes", {phaseWindow, pwmBlank, softStartEn}, 3'b110);
      tick();
    end
    chkState(3, "R3 phase exit");
  endtask

  task automatic testResetAndGate();
    chkState(0, "R1 reset");
    chk(!powerGood && pwmBlank, "R8 reset pg", powerGood, 0);
    enable = 1; uvloOk = 0;
    tick(3);
    chkState(0, "R1 gate uvlo");
    enable = 0; uvloOk = 1;
    tick(3);
    chkState(0, "R1 gate enable");
  endtask

  task automatic testFullSequence();
    startToRamp();
    tick(4);
    chkState(3, "R4 waits");
    chk(softStartEn && !refSelCode, "R4 boot ref", {softStartEn, refSelCode}, 2'b10);
    rampDone = 1;
    tick();
    rampDone = 0;
    for (int h = 0; h < TT; h++) begin
      chkState(4, "R5 hold");
      if (h < TT - 1) begin
        vidCode = 8'(h * 7 + 3);
        #1;
        chk(codeLatch == 0, "R5 no strobe", codeLatch, 0);
        chk(latchedCode == 0, "R5 ignored", latchedCode, 0);
      end else begin
        vidCode = 8'h5A;
        #1;
        chk(codeLatch == 1, "R5 strobe last", codeLatch, 1);
      end
      tick();
    end
    chkState(5, "R6 code ramp");
    chk(latchedCode == 8'h5A, "R5 captured", latchedCode, 8'h5A);
    chk(refSelCode && softStartEn, "R6 ref code", refSelCode, 1);
    vidCode = 8'h11;
    tick(3);
    chk(latchedCode == 8'h5A, "R6 held", latchedCode, 8'h5A);
    chkState(5, "R6 waits");
    rampDone = 1;
    tick();
    rampDone = 0;
    for (int m = 0; m < MT; m++) begin
      chkState(6, "R7 mask");
      chk(!powerGood, "R8 pg mask", powerGood, 0);
      tick();
    end
    for (int d = 0; d < TT; d++) begin
      chkState(7, "R7 pg delay");
      chk(!powerGood, "R8 pg delay", powerGood, 0);
      tick();
    end
    chkState(8, "R7 run");
    chk(powerGood, "R8 pg run", powerGood, 1);
    tick(2);
    chk(powerGood && latchedCode == 8'h5A, "R6 run held", latchedCode, 8'h5A);
    uvloOk = 0;
    #1;
    chk(!powerGood, "R8 pg drop same cycle", powerGood, 0);
    tick();
    chkState(0, "R1 abort from run");
    uvloOk = 1;
    enable = 0;
    tick();
  endtask

  task automatic testAbortPhase();
    enable = 1; uvloOk = 1;
    tick(TT + 2);
    chkState(2, "R1 in phase");
    enable = 0;
    tick();
    chkState(0, "R1 abort phase");
    chk(!phaseWindow && !softStartEn, "R1 idle strobes", phaseWindow, 0);
    enable = 1;
    tick();
    chkState(1, "R1 restart");
    tick(TT);
    chkState(2, "R2 restart delay");
    enable = 0;
    tick();
  endtask

  initial begin
    tick(2);
    rstN = 1;
    tick();
    testResetAndGate();
    testFullSequence();
    testAbortPhase();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule